// File: doc/BRIEF.md
# Input Capture Unit with Noise Filter

This block records the value of a free-running timer counter at the moment a chosen signal changes level. The trigger comes from one of two places: an external capture pin or the output of an analog comparator. It passes through a two-stage synchronizer and, when enabled, through a digital noise filter. An edge detector then looks for the selected direction, rising or falling. On each qualified edge the counter value is copied into the capture register. A one-cycle event strobe also goes to the interrupt flag logic, which sits outside this block.

When the capture register is in use as the counter's TOP value, the surrounding timer raises a lock input. Events then still produce the strobe but leave the stored value untouched. The filter accepts a new level only after four consecutive equal samples. Short spikes are therefore dropped, at the cost of four extra cycles of latency.

Top module: `capture_unit`

## Requirements
- R1: On a qualified edge the capture register takes the `count_i` value present in the cycle before the strobe rises, and it holds that value until the next qualified edge.
- R2: `src_sel_i` = 0 selects `pin_i` as the trigger and `src_sel_i` = 1 selects `cmp_i`; level changes on the unselected input produce no event and no capture.
- R3: `edge_sel_i` = 1 qualifies rising edges (0 to 1) and `edge_sel_i` = 0 qualifies falling edges (1 to 0); an edge of the other direction is ignored.
- R4: With the filter off, a trigger level first sampled at clock edge k raises `cap_evt_o` after clock edge k+2; a level held across a single clock edge is enough.
- R5: With the filter on, the same change raises `cap_evt_o` after clock edge k+6, four cycles later than with the filter off.
- R6: With the filter on, a level held for fewer than four sampled cycles is rejected, and a level held for four or more is accepted.
- R7: While `top_lock_i` = 1, a qualified edge still pulses `cap_evt_o` but the capture register keeps its previous value.
- R8: Synchronous active-low reset clears the capture register, the strobe, the synchronizer, the filter and the edge history to 0. A trigger held low after reset produces no event.
- R9: `cap_evt_o` is high for exactly one cycle per qualified edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | CNT_W | Current timer counter value |
| pin_i | input | 1 | External capture pin (asynchronous) |
| cmp_i | input | 1 | Analog comparator output (asynchronous) |
| src_sel_i | input | 1 | Trigger source: 0 pin, 1 comparator |
| edge_sel_i | input | 1 | Edge direction: 1 rising, 0 falling |
| filt_en_i | input | 1 | 1 enables the four-sample noise filter |
| top_lock_i | input | 1 | 1 while the capture register serves as TOP; blocks overwrite |
| cap_val_o | output | CNT_W | Capture register value |
| cap_evt_o | output | 1 | One-cycle capture event strobe to the flag logic |

## Verification
A sequence of level changes walks through both sources, both edge directions, the filter on and off, and the lock on and off. Each step holds a distinct counter value, so a missing capture, a wrong capture and a capture from the wrong input all show up as different register contents. Directed cycle-exact checks separate the two latencies, three and seven edges. Spike tests of one, three and four cycles find the boundary where the filter starts to accept a level. A mid-run reset confirms that the stored value is cleared.

// File: rtl/icu_pkg.sv
// Package: shared encodings for the input capture unit.
// Assumes: single clock domain downstream of the synchronizer.
package icu_pkg;

    // Trigger source selection, matches the src_sel_i port encoding.
    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_CMP = 1'b1
    } trig_src_e;

    // Edge polarity selection, matches the edge_sel_i port encoding.
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_pol_e;

    localparam int unsigned DEF_CNT_W    = 16;
    localparam int unsigned DEF_SYNC_LEN = 2;
    localparam int unsigned DEF_FILT_LEN = 4;

endpackage

// File: rtl/icu_sync.sv
// Module: icu_sync
// Brings an asynchronous level into the clock domain through a chain of
// flops. Assumes STAGES >= 2 and that the input may change at any time.
module icu_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/icu_filter.sv
// Module: icu_filter
// Majority-free noise canceler: the output level changes only when the
// last FILT_LEN input samples are all equal. Adds FILT_LEN cycles of delay.
// Assumes the input is already synchronous and FILT_LEN >= 2.
module icu_filter #(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic level_o
);

    localparam int unsigned HIST_W = FILT_LEN - 1;

    logic [HIST_W-1:0]   hist_q;
    logic [FILT_LEN-1:0] window;
    logic                all_high;
    logic                all_low;
    logic                filt_q;

    assign window   = {hist_q, level_i};
    assign all_high = &window;
    assign all_low  = ~|window;

    // Keep the most recent samples of the synchronized input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= window[HIST_W-1:0];
        end
    end

    // Accept a new level only when the whole window agrees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
        end else if (all_high) begin
            filt_q <= 1'b1;
        end else if (all_low) begin
            filt_q <= 1'b0;
        end
    end

    assign level_o = filt_q;

    generate
        if (FILT_LEN == 4) begin : g_chk4
            // R6: a change of the filtered level follows four equal samples.
            p_filt_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (filt_q != $past(filt_q)) |->
                    ($past(level_i, 1) == filt_q && $past(level_i, 2) == filt_q &&
                     $past(level_i, 3) == filt_q && $past(level_i, 4) == filt_q))
                else $error("p_filt_settle_r6");
        end
    endgenerate

endmodule

// File: rtl/icu_edge_det.sv
// Module: icu_edge_det
// Flags a level transition in the selected direction. The output is
// combinational from the current level and one flop of history.
// Assumes a synchronous, already filtered level.
module icu_edge_det
    import icu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level_i,
    input  edge_pol_e pol_i,
    output logic      edge_o
);

    logic prev_q;
    logic pol_level;

    assign pol_level = (pol_i == EDGE_RISE);

    // Remember the previous level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level_i;
        end
    end

    // A transition counts when the new level matches the chosen polarity.
    always_comb begin
        edge_o = (level_i != prev_q) && (level_i == pol_level);
    end

endmodule

// File: rtl/capture_unit.sv
// Module: capture_unit
// Input capture: selects a trigger, synchronizes it, optionally filters
// it, detects the chosen edge and latches the counter value. Emits a
// one-cycle event strobe for the flag logic outside this block.
// Assumes count_i is synchronous to clk; top_lock_i is driven by the
// timer when the capture register serves as TOP.
module capture_unit
    import icu_pkg::*;
#(
    parameter int unsigned CNT_W    = DEF_CNT_W,
    parameter int unsigned SYNC_LEN = DEF_SYNC_LEN,
    parameter int unsigned FILT_LEN = DEF_FILT_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             pin_i,
    input  logic             cmp_i,
    input  logic             src_sel_i,
    input  logic             edge_sel_i,
    input  logic             filt_en_i,
    input  logic             top_lock_i,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             cap_evt_o
);

    trig_src_e        src_sel;
    edge_pol_e        edge_pol;
    logic             trig_raw;
    logic             trig_sync;
    logic             trig_filt;
    logic             det_level;
    logic             edge_hit;
    logic [CNT_W-1:0] cap_q;
    logic             evt_q;

    assign src_sel  = trig_src_e'(src_sel_i);
    assign edge_pol = edge_pol_e'(edge_sel_i);

    // Pick the trigger source before synchronization.
    always_comb begin
        trig_raw = (src_sel == SRC_CMP) ? cmp_i : pin_i;
    end

    icu_sync #(
        .STAGES (SYNC_LEN)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (trig_raw),
        .sync_o  (trig_sync)
    );

    icu_filter #(
        .FILT_LEN (FILT_LEN)
    ) filt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (trig_sync),
        .level_o (trig_filt)
    );

    // Choose the filtered or the direct level for edge detection.
    always_comb begin
        det_level = filt_en_i ? trig_filt : trig_sync;
    end

    icu_edge_det edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (det_level),
        .pol_i   (edge_pol),
        .edge_o  (edge_hit)
    );

    // Latch the counter on a qualified edge unless the register is TOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (edge_hit && !top_lock_i) begin
            cap_q <= count_i;
        end
    end

    // Register the event strobe for the flag logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= edge_hit;
        end
    end

    assign cap_val_o = cap_q;
    assign cap_evt_o = evt_q;

    // R1: the stored value only changes together with an event strobe.
    p_cap_on_evt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q != $past(cap_q)) |-> evt_q)
        else $error("p_cap_on_evt_r1");

    // R3: an event follows a detected level equal to the chosen polarity.
    p_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> ($past(det_level) == $past(edge_sel_i)))
        else $error("p_dir_r3");

    // R7: while locked the capture register does not move.
    p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        top_lock_i |=> (cap_q == $past(cap_q)))
        else $error("p_lock_hold_r7");

    // R9: the strobe never lasts two cycles.
    p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |=> !evt_q)
        else $error("p_single_r9");

endmodule

// File: tb/capture_unit_tb_top.sv
module capture_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] count_i = '0;
    logic        pin_i = 1'b0;
    logic        cmp_i = 1'b0;
    logic        src_sel_i = 1'b0;
    logic        edge_sel_i = 1'b1;
    logic        filt_en_i = 1'b0;
    logic        top_lock_i = 1'b0;
    logic [15:0] cap_val_o;
    logic        cap_evt_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    capture_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_i    (count_i),
        .pin_i      (pin_i),
        .cmp_i      (cmp_i),
        .src_sel_i  (src_sel_i),
        .edge_sel_i (edge_sel_i),
        .filt_en_i  (filt_en_i),
        .top_lock_i (top_lock_i),
        .cap_val_o  (cap_val_o),
        .cap_evt_o  (cap_evt_o)
    );

    typedef struct packed {
        logic        src;
        logic        rise;
        logic        filt;
        logic        lock;
        logic        pin;
        logic        cmp;
        logic [15:0] cnt;
        logic [1:0]  evts;
        logic [15:0] cap;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1111, 2'd1, 16'h1111}, // R1 R3 pin rise
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2222, 2'd0, 16'h1111}, // R3 fall ignored
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h3333, 2'd0, 16'h1111}, // R3 rise ignored
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h4444, 2'd1, 16'h4444}, // R3 fall taken
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h5555, 2'd1, 16'h5555}, // R2 comparator
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h6666, 2'd0, 16'h5555}, // R2 pin ignored
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h7777, 2'd0, 16'h5555}, // R2 cmp fall
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h8888, 2'd1, 16'h8888}, // R6 long level
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h9990, 2'd0, 16'h8888}, // R7 setup
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h9999, 2'd1, 16'h8888}, // R7 locked
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hAAAA, 2'd1, 16'hAAAA}  // R7 unlocked
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Run n cycles and return how many had the strobe high.
    task automatic count_evts(input int n, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            cyc();
            if (cap_evt_o) k++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k;
        @(negedge clk);
        repeat (3) cyc();
        check("R8 reset cap", cap_val_o, 0);
        check("R8 reset evt", cap_evt_o, 0);
        rst_n = 1'b1;
        count_evts(10, k);
        check("R8 idle low no event", k, 0);

        // Vector walk
        for (int v = 0; v < NVEC; v++) begin
            src_sel_i  = VECS[v].src;
            edge_sel_i = VECS[v].rise;
            filt_en_i  = VECS[v].filt;
            top_lock_i = VECS[v].lock;
            pin_i      = VECS[v].pin;
            cmp_i      = VECS[v].cmp;
            count_i    = VECS[v].cnt;
            count_evts(12, k);
            check($sformatf("R1/R2/R3/R7 vec %0d events", v), k, VECS[v].evts);
            check($sformatf("R1/R2/R3/R7 vec %0d cap", v), cap_val_o, VECS[v].cap);
        end

        // R4 latency with filter off
        filt_en_i = 1'b0; edge_sel_i = 1'b1; count_i = 16'h0B0B;
        count_evts(10, k);
        pin_i = 1'b1;
        cyc(); cyc();
        check("R4 no event after edge k+1", cap_evt_o, 0);
        cyc();
        check("R4 event after edge k+2", cap_evt_o, 1);
        check("R1 value latched", cap_val_o, 16'h0B0B);
        cyc();
        check("R9 strobe one cycle", cap_evt_o, 0);

        // R5 latency with filter on
        pin_i = 1'b0; filt_en_i = 1'b1; count_i = 16'h0C0C;
        count_evts(12, k);
        pin_i = 1'b1;
        repeat (6) cyc();
        check("R5 no event after edge k+5", cap_evt_o, 0);
        cyc();
        check("R5 event after edge k+6", cap_evt_o, 1);
        check("R5 value latched", cap_val_o, 16'h0C0C);

        // R6 spike of three cycles rejected
        pin_i = 1'b0; count_i = 16'h0D0D;
        count_evts(12, k);
        pin_i = 1'b1;
        repeat (3) cyc();
        pin_i = 1'b0;
        count_evts(14, k);
        check("R6 three-cycle spike rejected", k, 0);
        check("R6 value kept", cap_val_o, 16'h0C0C);

        // R6 pulse of four cycles accepted
        pin_i = 1'b1;
        repeat (4) cyc();
        pin_i = 1'b0;
        count_evts(14, k);
        check("R6 four-cycle pulse accepted", k, 1);
        check("R6 value taken", cap_val_o, 16'h0D0D);

        // R4 one-cycle spike passes with filter off
        filt_en_i = 1'b0; count_i = 16'h0E0E;
        count_evts(8, k);
        pin_i = 1'b1;
        cyc();
        pin_i = 1'b0;
        count_evts(8, k);
        check("R4 single-cycle level accepted", k, 1);
        check("R4 value taken", cap_val_o, 16'h0E0E);

        // R8 mid-run reset clears capture
        rst_n = 1'b0;
        cyc(); cyc();
        check("R8 reset clears cap", cap_val_o, 0);
        rst_n = 1'b1;
        count_evts(6, k);
        check("R8 no event after reset", k, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule